// File: doc/BRIEF.md
# Triggered ADC conversion controller

This block sequences a 10-bit successive-approximation converter. A small register port carries writes to two registers: a mode register and a channel register. The channel register picks one of four analog inputs, driven out on `mux_sel`. The block drives a trial code to the external reference ladder on `dac_code`. It reads back the comparator decision on `cmp_in`, one bit per step, from the most significant bit down. When the last step is done, the final code goes into the result register and `irq` pulses for one clock.

Conversions start in one of two ways. In software mode, writing the mode register with the enable bit set and the trigger bit clear starts a conversion. Conversions then repeat back to back while the block stays enabled. In hardware mode the block waits in standby for a valid edge on `trig_in`. The edge polarity is programmable, and each valid edge starts exactly one conversion. A channel write during a hardware conversion aborts it and returns the block to standby. A mode write with the enable bit clear stops everything at once.

There is no streaming interface. The result is a plain register and `irq` is a plain pulse with no handshake and no back-pressure. A consumer must take `result` before the next conversion completes.

Top module: `adc_trig_ctrl`

## Requirements
- R1: A write with `reg_sel`=1 loads `reg_wdata[1:0]` into the channel register, and `mux_sel` shows that channel on the next cycle.
- R2: Mode register bit 7 is enable and bit 6 selects hardware trigger. With both set, the block sits in standby with `busy` low and starts nothing until a valid trigger edge.
- R3: Mode bits [2:1] select the trigger edge: 00 falling, 01 rising, 10 no edge ever valid, 11 both. `trig_in` passes through a two-flop synchronizer before edge detection.
- R4: When a conversion completes, `result` takes the converted code and `irq` is high in that same cycle, for exactly one cycle. `result` changes at no other time.
- R5: In hardware mode each valid edge starts one conversion. After it completes, no further conversion begins until another valid edge arrives.
- R6: A channel write during a hardware conversion aborts it: `busy` falls on the next cycle and `result` keeps its old value. The next valid edge converts the new channel from the first step.
- R7: A channel write in standby starts no conversion. The next valid edge converts the newly selected channel.
- R8: A mode write with bit 7 clear halts any conversion at once (`busy` low the next cycle), with no `irq` and no `result` update.
- R9: A mode write with bit 7 set and bit 6 clear starts a conversion. In this mode conversions follow one another back to back while enabled.
- R10: In software mode a channel write restarts the conversion immediately on the new channel.
- R11: A conversion runs 10 steps from MSB to LSB, each lasting STEP_CLKS clocks. Each step sets the trial bit on `dac_code` and keeps it only if `cmp_in` is 1. With STEP_CLKS=2, `irq` is seen 22 clocks after the clock edge that takes the start write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the mode register, 1 the channel register |
| reg_wdata | input | 8 | Write data |
| trig_in | input | 1 | Asynchronous external trigger |
| cmp_in | input | 1 | Comparator decision: 1 when the input is at or above the trial code |
| mux_sel | output | 2 | Selected analog channel |
| dac_code | output | 10 | Trial code for the reference ladder |
| result | output | 10 | Last completed conversion |
| irq | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Conversion in progress |

## Verification
The embedded assertions check the following on every cycle:
- `irq` stays a single-cycle pulse.
- `result` moves only together with `irq`.
- A disabling write leaves the block idle and silent on the next cycle.
- Standby never overlaps a running conversion.
- A finished hardware conversion returns to standby.
- The reserved edge code never yields a trigger.

The directed scenarios cover what needs a whole conversion or an analog model. This includes the converted values for each channel, the exact conversion latency, and the polarity selection. It also includes the abort and re-arm sequences on channel rewrites, and the absence of any conversion after a one-shot completes.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_NONE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_STANDBY = 2'd1,
    ST_CONV    = 2'd2
  } ctrl_state_e;

  typedef struct packed {
    logic      enable;
    logic      hw_trig;
    edge_sel_e edge_sel;
  } mode_cfg_t;

  localparam int MODE_EN_BIT   = 7;
  localparam int MODE_HW_BIT   = 6;
  localparam int MODE_EDGE_LSB = 1;
endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge
  import adc_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      trig_in,
  input  edge_sel_e edge_sel,
  output logic      hit
);
  logic [SYNC_STAGES:0] chain;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC_STAGES-1:0], trig_in};
  end

  assign rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
  assign fall = ~chain[SYNC_STAGES-1] & chain[SYNC_STAGES];

  always_comb begin
    unique case (edge_sel)
      EDGE_FALL: hit = fall;
      EDGE_RISE: hit = rise;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  AST_RESERVED_EDGE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel == EDGE_NONE) |-> !hit); // R3
endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine #(
  parameter int DATA_W    = 10,
  parameter int STEP_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              cmp_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] code
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int CNT_W = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CLKS - 1);
  localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(DATA_W - 1);

  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      code <= '0;
      idx  <= '0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      done <= 1'b0;
      code <= {1'b1, {(DATA_W-1){1'b0}}};
      idx  <= IDX_TOP;
      cnt  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else if (busy) begin
      done <= 1'b0;
      if (cnt == CNT_LAST) begin
        cnt <= '0;
        if (!cmp_in) code[idx] <= 1'b0;
        if (idx == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          code[idx - IDX_W'(1)] <= 1'b1;
          idx <= idx - IDX_W'(1);
        end
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end else begin
      done <= 1'b0;
    end
  end

  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy)); // R11
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int CH_W        = 2,
  parameter int STEP_CLKS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [7:0]        reg_wdata,
  input  logic              trig_in,
  input  logic              cmp_in,
  output logic [CH_W-1:0]   mux_sel,
  output logic [DATA_W-1:0] dac_code,
  output logic [DATA_W-1:0] result,
  output logic              irq,
  output logic              busy
);
  mode_cfg_t   mode_q;
  ctrl_state_e state, state_n;
  logic        mode_wr, chan_wr, edge_hit;
  logic        sar_start, sar_abort, sar_done;

  assign mode_wr = reg_wr & ~reg_sel;
  assign chan_wr = reg_wr & reg_sel;

  adc_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
    .edge_sel(mode_q.edge_sel), .hit(edge_hit)
  );

  adc_sar_engine #(.DATA_W(DATA_W), .STEP_CLKS(STEP_CLKS)) u_sar (
    .clk(clk), .rst_n(rst_n), .start(sar_start), .abort(sar_abort),
    .cmp_in(cmp_in), .busy(busy), .done(sar_done), .code(dac_code)
  );

  always_comb begin
    state_n   = state;
    sar_start = 1'b0;
    sar_abort = 1'b0;
    if (mode_wr) begin
      if (!reg_wdata[MODE_EN_BIT]) begin
        state_n = ST_IDLE;  sar_abort = 1'b1;
      end else if (reg_wdata[MODE_HW_BIT]) begin
        state_n = ST_STANDBY;  sar_abort = 1'b1;
      end else begin
        state_n = ST_CONV;  sar_start = 1'b1;
      end
    end else if (chan_wr && state != ST_IDLE) begin
      if (mode_q.hw_trig) begin
        state_n = ST_STANDBY;  sar_abort = 1'b1;
      end else begin
        state_n = ST_CONV;  sar_start = 1'b1;
      end
    end else begin
      unique case (state)
        ST_STANDBY: if (edge_hit) begin
          state_n = ST_CONV;  sar_start = 1'b1;
        end
        ST_CONV: if (sar_done) begin
          if (mode_q.hw_trig) state_n = ST_STANDBY;
          else sar_start = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      mode_q  <= '{enable: 1'b0, hw_trig: 1'b0, edge_sel: EDGE_FALL};
      mux_sel <= '0;
      result  <= '0;
      irq     <= 1'b0;
    end else begin
      state <= state_n;
      if (mode_wr) begin
        mode_q.enable   <= reg_wdata[MODE_EN_BIT];
        mode_q.hw_trig  <= reg_wdata[MODE_HW_BIT];
        mode_q.edge_sel <= edge_sel_e'(reg_wdata[MODE_EDGE_LSB +: 2]);
      end
      if (chan_wr) mux_sel <= reg_wdata[CH_W-1:0];
      irq <= sar_done & ~sar_abort;
      if (sar_done && !sar_abort) result <= dac_code;
    end
  end

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R4
  AST_RESULT_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> $stable(result)); // R4
  AST_DISABLE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !reg_wdata[MODE_EN_BIT]) |=> (!busy && !irq)); // R8
  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STANDBY) |-> !busy); // R2
  AST_HW_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (sar_done && mode_q.hw_trig && !reg_wr && state == ST_CONV) |=> (state == ST_STANDBY)); // R5
endmodule

// File: tb/sim_adc_trig_ctrl.sv
module sim_adc_trig_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       trig_in = 1'b0;
  logic       cmp_in;
  logic [1:0] mux_sel;
  logic [9:0] dac_code, result;
  logic       irq, busy;
  int checks = 0, errors = 0;
  logic [9:0] vin [4];

  always #2 clk = ~clk;

  adc_trig_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .trig_in(trig_in), .cmp_in(cmp_in),
    .mux_sel(mux_sel), .dac_code(dac_code), .result(result),
    .irq(irq), .busy(busy)
  );

  assign cmp_in = (dac_code <= vin[mux_sel]);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic sel, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  // write, then count clock edges until irq is seen
  task automatic write_timed(input logic sel, input logic [7:0] d, output int cyc);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    cyc = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); cyc++;
      @(negedge clk); reg_wr = 1'b0;
      if (irq) break;
    end
  endtask

  task automatic wait_irq(input int lim, output bit got);
    got = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (irq) begin got = 1; break; end
    end
  endtask

  task automatic set_trig(input logic v);
    @(negedge clk); trig_in = v;
  endtask

  task automatic t_reset;
    check(result == 0, "R4 reset result", result, 0);
    check(!irq && !busy, "R4 reset irq/busy", {irq, busy}, 0);
    check(mux_sel == 0, "R1 reset channel", mux_sel, 0);
  endtask

  task automatic t_software;
    int cyc; bit got;
    write_reg(1'b1, 8'h01);
    check(mux_sel == 1, "R1 channel output", mux_sel, 1);
    write_timed(1'b0, 8'h80, cyc);
    check(cyc == 22, "R11 conversion latency", cyc, 22);
    check(irq && result == vin[1], "R9 software result", result, vin[1]);
    @(negedge clk);
    check(!irq, "R4 irq single cycle", irq, 0);
    wait_irq(60, got);
    check(got && result == vin[1], "R9 back to back", result, vin[1]);
    repeat (5) @(negedge clk);
    write_timed(1'b1, 8'h02, cyc);
    check(cyc == 22 && result == vin[2], "R10 restart on channel write", cyc, 22);
    repeat (5) @(negedge clk);
    write_reg(1'b0, 8'h00);
    check(!busy, "R8 busy after disable", busy, 0);
    wait_irq(60, got);
    check(!got && result == vin[2], "R8 no result after disable", result, vin[2]);
  endtask

  task automatic t_hw_rise;
    bit got;
    write_reg(1'b1, 8'h00);
    write_reg(1'b0, 8'hC2);
    wait_irq(40, got);
    check(!got && !busy, "R2 standby waits", busy, 0);
    set_trig(1'b1);
    wait_irq(60, got);
    check(got && result == vin[0], "R3 rising edge converts", result, vin[0]);
    wait_irq(60, got);
    check(!got, "R5 one conversion per edge", got, 0);
    set_trig(1'b0);
    wait_irq(60, got);
    check(!got, "R3 falling ignored in rising mode", got, 0);
  endtask

  task automatic t_hw_fall_both_none;
    bit got;
    write_reg(1'b0, 8'hC0);
    set_trig(1'b1);
    wait_irq(60, got);
    check(!got, "R3 rising ignored in falling mode", got, 0);
    write_reg(1'b1, 8'h01);
    set_trig(1'b0);
    wait_irq(60, got);
    check(got && result == vin[1], "R3 falling edge converts", result, vin[1]);
    write_reg(1'b1, 8'h03);
    write_reg(1'b0, 8'hC6);
    set_trig(1'b1);
    wait_irq(60, got);
    check(got && result == vin[3], "R3 both mode rising", result, vin[3]);
    write_reg(1'b1, 8'h02);
    set_trig(1'b0);
    wait_irq(60, got);
    check(got && result == vin[2], "R3 both mode falling", result, vin[2]);
    write_reg(1'b0, 8'hC4);
    set_trig(1'b1);
    wait_irq(40, got);
    set_trig(1'b0);
    if (!got) wait_irq(40, got);
    check(!got && !busy, "R3 reserved code never triggers", got, 0);
  endtask

  task automatic t_abort;
    bit got;
    write_reg(1'b1, 8'h01);
    write_reg(1'b0, 8'hC2);
    repeat (4) @(negedge clk);
    set_trig(1'b1);
    for (int i = 0; i < 20 && !busy; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    check(busy, "R6 conversion running", busy, 1);
    write_reg(1'b1, 8'h03);
    check(!busy, "R6 abort on channel write", busy, 0);
    wait_irq(60, got);
    check(!got && result == vin[2], "R6 result kept after abort", result, vin[2]);
    set_trig(1'b0);
    repeat (4) @(negedge clk);
    set_trig(1'b1);
    wait_irq(60, got);
    check(got && result == vin[3], "R6 next edge converts new channel", result, vin[3]);
  endtask

  task automatic t_standby_chan;
    bit got;
    set_trig(1'b0);
    repeat (4) @(negedge clk);
    write_reg(1'b1, 8'h01);
    wait_irq(40, got);
    check(!got && !busy, "R7 standby write starts nothing", busy, 0);
    set_trig(1'b1);
    wait_irq(60, got);
    check(got && result == vin[1], "R7 edge uses new channel", result, vin[1]);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    vin[0] = 10'd300; vin[1] = 10'd777; vin[2] = 10'd1023; vin[3] = 10'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_software();
    t_hw_rise();
    t_hw_fall_both_none();
    t_abort();
    t_standby_chan();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule